// File: doc/BRIEF.md
# Backlight PWM Generator with Power-of-Two Prescaler

This block drives one pulse-width-modulated pin for a display backlight. A free-running 8-bit counter advances once per prescaled tick, so one output period is always 256 prescaled ticks long. The prescaled tick comes from one of two clock-enable strobes: a slow one and a system one. It is divided by a power of two chosen by a 3-bit code. An 8-bit compare value sets the duty cycle anywhere from 0/256 to 255/256, and a polarity bit picks whether the pin is high or low during the active part of the period.

Software reaches the block through a simple synchronous register port. Writes take effect at the clock edge, and the read data is a combinational function of the address. Compare value, polarity and prescaler code are written into a configuration register. They are copied into working (shadow) copies only when the counter wraps, so a period is never cut short or stretched by a change. Run control uses separate write-one-to-set and write-one-to-clear registers. A run-control state machine applies the request at the next counter wrap, and a status bit tells software when the output has really started or stopped.

The run-control machine has four states:

| State | Meaning |
|---|---|
| `RUN_OFF` | Idle; status reads 0. |
| `RUN_STARTING` | Start requested; status still 0. |
| `RUN_ON` | Output running; status reads 1. |
| `RUN_STOPPING` | Stop requested; status still 1. |

Its transitions are:

| From | Event | To |
|---|---|---|
| `RUN_OFF` | enable write | `RUN_STARTING`, or straight to `RUN_ON` if a wrap occurs in the same cycle |
| `RUN_STARTING` | wrap | `RUN_ON` |
| `RUN_STARTING` | disable write | `RUN_OFF` (the start is cancelled) |
| `RUN_ON` | disable write | `RUN_STOPPING`, or straight to `RUN_OFF` if a wrap occurs in the same cycle |
| `RUN_STOPPING` | wrap | `RUN_OFF` |
| `RUN_STOPPING` | enable write | `RUN_ON` (the stop is cancelled) |

All other events leave the state unchanged.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset all registers read 0, the status bit is 0, the slow tick is selected, and pwm_out is 1 (the idle level for polarity 0).
- R2: Register map by reg_addr: 0 = source select in bit 0; 1 = configuration with compare in bits 15:8, polarity in bit 4 and prescaler code in bits 2:0, all other bits reading 0; 2 = start (write 1 to bit 0); 3 = stop (write 1 to bit 0); 4 = status in bit 0. Addresses 2, 3 and unused addresses read 0.
- R3: When source-select bit 0 is 1, only sys_tick advances the prescaler; when it is 0, only slow_tick does, and the other strobe has no effect.
- R4: With active prescaler code p, the counter advances once every 2^p selected source ticks, and one period is 256 counter steps. Prescaler phase restarts at every wrap.
- R5: With polarity 1 and the output running, pwm_out is 1 exactly while counter < compare. Compare 0 gives an output that is never active, and compare 255 gives one that is active for 255 of the 256 steps.
- R6: With polarity 0, pwm_out is the inverse of the R5 waveform.
- R7: The status bit and the output gating change only at a counter wrap, to the state last requested through the start and stop registers.
- R8: While not running, pwm_out holds the inactive level, which is the inverse of the active polarity bit.
- R9: Writes to compare, polarity and prescaler code reach the output only at the next counter wrap.
- R10: A prescaler code of 7 is invalid. At the wrap it is not taken, and the previous prescaler stays in force, while compare and polarity are still taken.
- R11: With parameter NO_DIV1 = 1, a prescaler code of 0 takes effect as code 1, and the reset prescaler is 1.
- R12: A stop write before the wrap cancels a pending start, and status stays 0. A start write before the wrap cancels a pending stop, and status stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow clock-enable strobe |
| sys_tick | input | 1 | System clock-enable strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pwm_out | output | 1 | PWM output pin |

## Verification
The hardest situations to reach are those where a start or stop request meets the counter wrap. These include a request that is cancelled before the wrap and a prescaler change that has to wait for the wrap of a long period. The stimulus issues start/stop pairs a few cycles apart, well inside a period, so the cancelling transitions are taken. It also lets a full divide-by-64 period run out before switching to a short prescaler, and then writes the invalid code 7. A second instance, built as the no-divide-by-1 variant, runs on the same stimulus against its own reference model.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    typedef enum logic [1:0] {
        RUN_OFF,
        RUN_STARTING,
        RUN_ON,
        RUN_STOPPING
    } run_state_e;

    localparam int ADDR_SRC  = 0;
    localparam int ADDR_CFG  = 1;
    localparam int ADDR_SET  = 2;
    localparam int ADDR_CLR  = 3;
    localparam int ADDR_STAT = 4;

    localparam int CMP_LSB = 8;
    localparam int POL_BIT = 4;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 8,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              running,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              src_sel,
    output logic [CNT_W-1:0]  cfg_cmp,
    output logic              cfg_pol,
    output logic [PS_W-1:0]   cfg_ps,
    output logic              en_req,
    output logic              dis_req
);
    logic wdata_unused;
    assign wdata_unused = ^reg_wdata;

    assign en_req  = reg_we && (reg_addr == ADDR_W'(ADDR_SET)) && reg_wdata[0];
    assign dis_req = reg_we && (reg_addr == ADDR_W'(ADDR_CLR)) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel <= 1'b0;
            cfg_cmp <= '0;
            cfg_pol <= 1'b0;
            cfg_ps  <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(ADDR_SRC)) begin
                src_sel <= reg_wdata[0];
            end
            if (reg_addr == ADDR_W'(ADDR_CFG)) begin
                cfg_cmp <= reg_wdata[CMP_LSB +: CNT_W];
                cfg_pol <= reg_wdata[POL_BIT];
                cfg_ps  <= reg_wdata[PS_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_SRC)) begin
            reg_rdata[0] = src_sel;
        end else if (reg_addr == ADDR_W'(ADDR_CFG)) begin
            reg_rdata[CMP_LSB +: CNT_W] = cfg_cmp;
            reg_rdata[POL_BIT]          = cfg_pol;
            reg_rdata[PS_W-1:0]         = cfg_ps;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata[0] = running;
        end
    end

    AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_req && dis_req)); // R2
endmodule

// File: rtl/bl_pwm_prescale.sv
module bl_pwm_prescale #(
    parameter int PS_W   = 3,
    parameter int PS_MAX = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_tick,
    input  logic [PS_W-1:0] ps_code,
    input  logic            wrap,
    output logic            ptick
);
    localparam int DIV_W = (PS_MAX < 1) ? 1 : PS_MAX;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            div_mask[i] = (int'(ps_code) > i);
        end
    end

    assign ptick = src_tick && ((div_cnt & div_mask) == div_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (src_tick) begin
            div_cnt <= wrap ? '0 : div_cnt + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (ptick && !wrap && ps_code != '0) |=> !ptick); // R4
endmodule

// File: rtl/bl_pwm_timebase.sv
module bl_pwm_timebase #(
    parameter int CNT_W   = 8,
    parameter int PS_W    = 3,
    parameter int PS_MAX  = 6,
    parameter bit NO_DIV1 = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptick,
    input  logic [CNT_W-1:0] cfg_cmp,
    input  logic             cfg_pol,
    input  logic [PS_W-1:0]  cfg_ps,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic [CNT_W-1:0] cmp_sh,
    output logic             pol_sh,
    output logic [PS_W-1:0]  ps_sh
);
    localparam logic [PS_W-1:0] PS_RST = NO_DIV1 ? PS_W'(1) : '0;

    logic            ps_legal;
    logic [PS_W-1:0] ps_eff;

    assign wrap     = ptick && (cnt == '1);
    assign ps_legal = (cfg_ps <= PS_W'(PS_MAX));

    generate
        if (NO_DIV1) begin : g_nodiv1
            assign ps_eff = (cfg_ps == '0) ? PS_W'(1) : cfg_ps;
        end else begin : g_plain
            assign ps_eff = cfg_ps;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            cmp_sh <= '0;
            pol_sh <= 1'b0;
            ps_sh  <= PS_RST;
        end else begin
            if (ptick) begin
                cnt <= cnt + 1'b1;
            end
            if (wrap) begin
                cmp_sh <= cfg_cmp;
                pol_sh <= cfg_pol;
                if (ps_legal) begin
                    ps_sh <= ps_eff;
                end
            end
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ptick |=> $stable(cnt)); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(cmp_sh) && $stable(pol_sh) && $stable(ps_sh))); // R9
    AST_PS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ps_sh <= PS_W'(PS_MAX)); // R10

    generate
        if (NO_DIV1) begin : g_chk_nodiv1
            AST_NO_UNITY_DIV: assert property (@(posedge clk) disable iff (!rst_n)
                ps_sh != '0); // R11
        end
    endgenerate
endmodule

// File: rtl/bl_pwm_runctl.sv
module bl_pwm_runctl
    import bl_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic wrap,
    output logic running
);
    run_state_e state;
    run_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RUN_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RUN_OFF: begin
                if (en_req) begin
                    state_nxt = wrap ? RUN_ON : RUN_STARTING;
                end
            end
            RUN_STARTING: begin
                if (dis_req) begin
                    state_nxt = RUN_OFF;
                end else if (wrap) begin
                    state_nxt = RUN_ON;
                end
            end
            RUN_ON: begin
                if (dis_req) begin
                    state_nxt = wrap ? RUN_OFF : RUN_STOPPING;
                end
            end
            RUN_STOPPING: begin
                if (en_req) begin
                    state_nxt = RUN_ON;
                end else if (wrap) begin
                    state_nxt = RUN_OFF;
                end
            end
        endcase
    end

    always_comb begin
        running = (state == RUN_ON) || (state == RUN_STOPPING);
    end

    AST_STATUS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(running)); // R7
    AST_CANCEL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && dis_req) |=> !running); // R12
    AST_CANCEL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en_req) |=> running); // R12
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 8,
    parameter int PS_W    = 3,
    parameter int PS_MAX  = 6,
    parameter bit NO_DIV1 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              sys_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    logic             src_sel;
    logic [CNT_W-1:0] cfg_cmp;
    logic             cfg_pol;
    logic [PS_W-1:0]  cfg_ps;
    logic             en_req;
    logic             dis_req;
    logic             running;
    logic             src_tick;
    logic             ptick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_sh;
    logic             pol_sh;
    logic [PS_W-1:0]  ps_sh;
    logic             active;

    bl_pwm_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PS_W(PS_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .running(running), .reg_rdata(reg_rdata),
        .src_sel(src_sel), .cfg_cmp(cfg_cmp), .cfg_pol(cfg_pol),
        .cfg_ps(cfg_ps), .en_req(en_req), .dis_req(dis_req)
    );

    assign src_tick = src_sel ? sys_tick : slow_tick;

    bl_pwm_prescale #(
        .PS_W(PS_W), .PS_MAX(PS_MAX)
    ) u_prescale (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ps_code(ps_sh),
        .wrap(wrap), .ptick(ptick)
    );

    bl_pwm_timebase #(
        .CNT_W(CNT_W), .PS_W(PS_W), .PS_MAX(PS_MAX), .NO_DIV1(NO_DIV1)
    ) u_timebase (
        .clk(clk), .rst_n(rst_n), .ptick(ptick), .cfg_cmp(cfg_cmp),
        .cfg_pol(cfg_pol), .cfg_ps(cfg_ps), .cnt(cnt), .wrap(wrap),
        .cmp_sh(cmp_sh), .pol_sh(pol_sh), .ps_sh(ps_sh)
    );

    bl_pwm_runctl u_runctl (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .wrap(wrap), .running(running)
    );

    assign active  = running && (cnt < cmp_sh);
    assign pwm_out = pol_sh ? active : !active;

    AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) |-> (pwm_out == !pol_sh)); // R5
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_out == !pol_sh)); // R8
endmodule

// File: tb/tb_bl_pwm_top.sv
module bl_pwm_refmodel #(
    parameter bit NO_DIV1 = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_tick,
    input  logic        sys_tick,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        exp_out,
    output logic [31:0] exp_rdata
);
    int gsel, cmp, pol, ps;
    int cmp_a, pol_a, ps_a;
    int k, cnt, req, run;

    always @(posedge clk or negedge rst_n) begin
        int src, stepped, wrapped, nreq;
        if (!rst_n) begin
            gsel = 0; cmp = 0; pol = 0; ps = 0;
            cmp_a = 0; pol_a = 0; ps_a = NO_DIV1 ? 1 : 0;
            k = 0; cnt = 0; req = 0; run = 0;
        end else begin
            src = gsel ? int'(sys_tick) : int'(slow_tick);
            stepped = 0;
            wrapped = 0;
            if (src != 0) begin
                if (k == (1 << ps_a) - 1) begin
                    stepped = 1;
                    k = 0;
                end else begin
                    k = k + 1;
                end
            end
            if (stepped != 0) begin
                if (cnt == 255) begin
                    wrapped = 1;
                    cnt = 0;
                end else begin
                    cnt = cnt + 1;
                end
            end
            nreq = req;
            if (reg_we && reg_addr == 3'd2 && reg_wdata[0]) nreq = 1;
            if (reg_we && reg_addr == 3'd3 && reg_wdata[0]) nreq = 0;
            if (wrapped != 0) begin
                run   = nreq;
                cmp_a = cmp;
                pol_a = pol;
                if (ps <= 6) ps_a = (NO_DIV1 && ps == 0) ? 1 : ps;
            end
            req = nreq;
            if (reg_we && reg_addr == 3'd0) gsel = int'(reg_wdata[0]);
            if (reg_we && reg_addr == 3'd1) begin
                cmp = int'(reg_wdata[15:8]);
                pol = int'(reg_wdata[4]);
                ps  = int'(reg_wdata[2:0]);
            end
        end
    end

    always @* begin
        logic act;
        act = (run != 0) && (cnt < cmp_a);
        exp_out = (pol_a != 0) ? act : !act;
        case (reg_addr)
            3'd0:    exp_rdata = 32'(gsel);
            3'd1:    exp_rdata = 32'((cmp << 8) | (pol << 4) | ps);
            3'd4:    exp_rdata = 32'(run);
            default: exp_rdata = 32'd0;
        endcase
    end
endmodule

module tb_bl_pwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        sys_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] rdata_a, rdata_b, erd_a, erd_b;
    logic        out_a, out_b, eout_a, eout_b;

    int    n_checks = 0;
    int    n_fails = 0;
    bit    sys_every = 1'b1;
    bit    finished = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    bl_pwm_top dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sys_tick(sys_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_a), .pwm_out(out_a)
    );

    bl_pwm_top #(.NO_DIV1(1'b1)) dut_nd1 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sys_tick(sys_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_b), .pwm_out(out_b)
    );

    bl_pwm_refmodel #(.NO_DIV1(1'b0)) ref_a (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sys_tick(sys_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .exp_out(eout_a), .exp_rdata(erd_a)
    );

    bl_pwm_refmodel #(.NO_DIV1(1'b1)) ref_b (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sys_tick(sys_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .exp_out(eout_b), .exp_rdata(erd_b)
    );

    // Source strobes: slow tick once every 3 clocks, system tick every clock
    // or, when sys_every is cleared, two clocks out of three.
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph == 2) ? 0 : ph + 1;
            slow_tick = (ph == 0);
            sys_tick  = sys_every || (ph != 1);
        end
    end

    task automatic compare(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        compare("pwm_out", 32'(out_a), 32'(eout_a));
        compare("reg_rdata", rdata_a, erd_a);
        compare("pwm_out(nodiv1)", 32'(out_b), 32'(eout_b));
        compare("reg_rdata(nodiv1)", rdata_b, erd_b);
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        check_all();
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        check_all();
        reg_we = 1'b0;
    endtask

    task automatic look(input logic [2:0] a);
        @(negedge clk);
        check_all();
        reg_addr = a;
    endtask

    function automatic logic [31:0] cfgw(input int c, input int p, input int s);
        return 32'((c << 8) | (p << 4) | s);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        end
    endtask

    initial begin
        #(150000 * 10);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state on all addresses
        phase = "R1";
        run_cycles(3);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            look(3'(a));
            run_cycles(1);
        end

        // R2: register layout, reserved bits read 0, set/clear read 0
        phase = "R2";
        wr(3'd1, 32'hFFFF_FFFF);
        look(3'd1);
        run_cycles(2);
        wr(3'd0, 32'hFFFF_FFFE);
        look(3'd0);
        run_cycles(2);
        wr(3'd1, cfgw(64, 1, 0));
        look(3'd2);
        run_cycles(1);
        look(3'd3);
        run_cycles(1);

        // R7: start on the slow source, status rises only at the wrap
        phase = "R7";
        wr(3'd2, 32'h1);
        look(3'd4);
        run_cycles(900);

        // R3: slow source drives the period, then the system source
        phase = "R3";
        run_cycles(800);
        wr(3'd0, 32'h1);
        look(3'd4);
        sys_every = 1'b0;
        run_cycles(700);
        sys_every = 1'b1;
        run_cycles(300);

        // R5: compare 0 and compare 255 limits
        phase = "R5";
        wr(3'd1, cfgw(0, 1, 0));
        run_cycles(600);
        wr(3'd1, cfgw(255, 1, 0));
        run_cycles(600);

        // R6: inverted polarity
        phase = "R6";
        wr(3'd1, cfgw(100, 0, 0));
        run_cycles(600);

        // R9: several writes within one period, only the last one counts
        phase = "R9";
        run_cycles(37);
        wr(3'd1, cfgw(10, 1, 0));
        run_cycles(20);
        wr(3'd1, cfgw(200, 1, 0));
        run_cycles(600);

        // R4: divide by 4, then a full divide-by-64 period, then divide by 2
        phase = "R4";
        wr(3'd1, cfgw(90, 1, 2));
        run_cycles(2400);
        wr(3'd1, cfgw(30, 1, 6));
        run_cycles(1100 + 16500);
        wr(3'd1, cfgw(30, 1, 1));
        run_cycles(16500 + 1100);

        // R10: invalid code 7 keeps divide by 2, compare still changes
        phase = "R10";
        wr(3'd1, cfgw(150, 1, 7));
        run_cycles(1200);

        // R8: stop, output returns to the idle level after the wrap
        phase = "R8";
        wr(3'd1, cfgw(150, 1, 0));
        run_cycles(600);
        wr(3'd3, 32'h1);
        look(3'd4);
        run_cycles(600);
        wr(3'd1, cfgw(150, 0, 0));
        run_cycles(600);

        // R12: start cancelled by stop, stop cancelled by start
        phase = "R12";
        wr(3'd2, 32'h1);
        run_cycles(20);
        wr(3'd3, 32'h1);
        look(3'd4);
        run_cycles(600);
        wr(3'd2, 32'h1);
        look(3'd4);
        run_cycles(600);
        wr(3'd3, 32'h1);
        run_cycles(20);
        wr(3'd2, 32'h1);
        look(3'd4);
        run_cycles(600);

        // R11: code 0 in the no-divide-by-1 instance acts as code 1
        phase = "R11";
        wr(3'd1, cfgw(70, 1, 0));
        run_cycles(1200);
        wr(3'd1, cfgw(70, 1, 3));
        run_cycles(2100);

        summary();
        $finish;
    end
endmodule